// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is the configuration slave of a video timing chip. An external controller reaches a small register file over three lines: an active-low frame enable, a serial clock, and one data line that carries command bits into the block and, for reads, carries register contents back out. The pad itself is outside the block. The block presents the incoming level on `ser_din`, the outgoing level on `ser_dout`, and a turn-around enable on `ser_doe`.

Each frame holds exactly sixteen bits, sent most significant bit first. The first bit selects the direction. Seven address bits follow, then eight data bits. Writes land in a set of writable configuration registers, and each of these drives an output port used by the neighbouring timing logic. Reads return either a writable register or one of five read-only status bytes that other blocks supply. The serial lines are oversampled by the core clock through synchronisers, so the block has a single clock domain. The core clock must run at least 25 times faster than the serial clock.

One bit of the control register asks for a reset of the rest of the chip. The block brings that bit out as a level and never uses it to clear its own state.

Top module: `serreg_if`

## Requirements
- R1: A frame starts when `ser_en_n` falls. The block samples `ser_din` on each of the first 16 rising edges of `ser_clk`. Bit 1 is the operation (0 = write, 1 = read), bits 2 to 8 are the address MSB first, and bits 9 to 16 are the data MSB first.
- R2: A complete write frame to a writable address (1, 2, 3, 4, 5, 6 or 9) places the data byte on that register's `cfg_reg*` port before the next frame begins.
- R3: In a read frame, the block drives data bit 7 on the falling edge after the 8th rising edge, and the next lower bit on each later falling edge, so the controller samples them on rising edges 9 to 16. `ser_doe` is 1 from that first falling edge until `ser_en_n` rises, and 0 at every other sampling edge and during every write frame.
- R4: After reset, the writable registers hold: address 1 = 0x00, 2 = 0x10, 3 = 0x90, 4 = 0x4F, 5 = 0x00, 6 = 0x22, 9 = 0x00. `ser_doe` is 0.
- R5: Addresses 7, 8, 13, 14 and 16 read back the inputs `sts_reg7`, `sts_reg8`, `sts_reg13`, `sts_reg14` and `sts_reg16`. Writes to these addresses change nothing.
- R6: `soft_rst` follows bit 7 of register 1. Setting it alters no other register and does not disturb the serial port.
- R7: If `ser_en_n` rises before the 16th rising edge, the frame is dropped and no register changes.
- R8: Reads of any address not listed in R2 or R5 return 0x00. Writes to such addresses change no `cfg_reg*` port.
- R9: Rising edges after the 16th, while `ser_en_n` is still low, are ignored. The frame's write takes effect once and holds.
- R10: With a 125 MHz core clock, frames run correctly at a 5 MHz serial clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock from the controller |
| ser_en_n | input | 1 | Active-low frame enable |
| ser_din | input | 1 | Level seen on the shared data line |
| ser_dout | output | 1 | Read data to drive onto the data line |
| ser_doe | output | 1 | Drive enable for the data line |
| sts_reg7 | input | 8 | Status byte read at address 7 |
| sts_reg8 | input | 8 | Status byte read at address 8 |
| sts_reg13 | input | 8 | Status byte read at address 13 |
| sts_reg14 | input | 8 | Status byte read at address 14 |
| sts_reg16 | input | 8 | Status byte read at address 16 |
| cfg_reg1 | output | 8 | Control register at address 1 |
| cfg_reg2 | output | 8 | Configuration register at address 2 |
| cfg_reg3 | output | 8 | Configuration register at address 3 |
| cfg_reg4 | output | 8 | Configuration register at address 4 |
| cfg_reg5 | output | 8 | Configuration register at address 5 |
| cfg_reg6 | output | 8 | Configuration register at address 6 |
| cfg_reg9 | output | 8 | Configuration register at address 9 |
| soft_rst | output | 1 | Chip reset request, bit 7 of register 1 |

## Verification
The assertions assume the controller holds `ser_din` steady for several core cycles around each rising edge of `ser_clk`. They also assume each serial clock phase spans more than the synchroniser depth plus one core cycle, so no rising and falling edge fall into the same sampled step. The bench keeps within these limits by changing data only on falling edges and by running the serial clock at 5 MHz against a 125 MHz core clock, which gives 12 core cycles per phase. It also idles `ser_clk` low with the enable high between frames, and it leaves the data line to the block only during read data phases.

// File: rtl/serreg_pkg.sv
package serreg_pkg;
  localparam int ADDR_W    = 7;
  localparam int DATA_W    = 8;
  localparam int FRAME_LEN = 1 + ADDR_W + DATA_W;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);
  localparam int SH_W      = FRAME_LEN - 2;
  localparam int DB_W      = $clog2(DATA_W);

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] byte_t;

  localparam int NUM_RW = 7;
  localparam addr_t RW_ADDR [NUM_RW] = '{7'd1, 7'd2, 7'd3, 7'd4, 7'd5, 7'd6, 7'd9};
  localparam byte_t RW_RST  [NUM_RW] = '{8'h00, 8'h10, 8'h90, 8'h4F, 8'h00, 8'h22, 8'h00};

  localparam int NUM_RO = 5;
  localparam addr_t RO_ADDR [NUM_RO] = '{7'd7, 7'd8, 7'd13, 7'd14, 7'd16};

  localparam int SRST_IDX = 0;
  localparam int SRST_BIT = 7;
endpackage

// File: rtl/serreg_sync.sv
module serreg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic sen_ni,
  input  logic sdi_i,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic frame_act,
  output logic sdi_s
);
  logic [STAGES-1:0] sclk_q, sclk_d;
  logic [STAGES-1:0] sen_q, sen_d;
  logic [STAGES-1:0] sdi_q, sdi_d;
  logic              sclk_prev_q, sclk_prev_d;

  always_comb begin
    sclk_d      = {sclk_q[STAGES-2:0], sclk_i};
    sen_d       = {sen_q[STAGES-2:0], sen_ni};
    sdi_d       = {sdi_q[STAGES-2:0], sdi_i};
    sclk_prev_d = sclk_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q      <= '0;
      sen_q       <= '1;
      sdi_q       <= '0;
      sclk_prev_q <= 1'b0;
    end else begin
      sclk_q      <= sclk_d;
      sen_q       <= sen_d;
      sdi_q       <= sdi_d;
      sclk_prev_q <= sclk_prev_d;
    end
  end

  assign sclk_rise = sclk_q[STAGES-1] & ~sclk_prev_q;
  assign sclk_fall = ~sclk_q[STAGES-1] & sclk_prev_q;
  assign frame_act = ~sen_q[STAGES-1];
  assign sdi_s     = sdi_q[STAGES-1];
endmodule

// File: rtl/serreg_frame.sv
module serreg_frame
  import serreg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sclk_rise,
  input  logic  sclk_fall,
  input  logic  frame_act,
  input  logic  sdi_s,
  input  byte_t rd_data,
  output addr_t rd_addr,
  output logic  wr_stb,
  output addr_t wr_addr,
  output byte_t wr_data,
  output logic  sdo,
  output logic  sdo_oe
);
  localparam logic [CNT_W-1:0] C_FULL  = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] C_LAST  = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] C_DATA0 = CNT_W'(1 + ADDR_W);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SH_W-1:0]  sh_q, sh_d;
  logic             rd_q, rd_d;
  byte_t            shadow_q, shadow_d;
  logic             sdo_q, sdo_d;
  logic             oe_q, oe_d;
  logic             stb_q, stb_d;
  addr_t            waddr_q, waddr_d;
  byte_t            wdata_q, wdata_d;
  logic [CNT_W-1:0] bit_idx;

  assign bit_idx = C_LAST - cnt_q;

  always_comb begin
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    rd_d     = rd_q;
    shadow_d = shadow_q;
    sdo_d    = sdo_q;
    oe_d     = oe_q;
    stb_d    = 1'b0;
    waddr_d  = waddr_q;
    wdata_d  = wdata_q;
    if (!frame_act) begin
      cnt_d = '0;
      rd_d  = 1'b0;
      sdo_d = 1'b0;
      oe_d  = 1'b0;
    end else begin
      if (sclk_rise && cnt_q < C_FULL) begin
        sh_d  = {sh_q[SH_W-2:0], sdi_s};
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == '0) rd_d = sdi_s;
        if (cnt_q == C_LAST && !rd_q) begin
          stb_d   = 1'b1;
          waddr_d = sh_q[DATA_W+ADDR_W-2 -: ADDR_W];
          wdata_d = {sh_q[DATA_W-2:0], sdi_s};
        end
      end
      if (sclk_fall && rd_q && cnt_q >= C_DATA0 && cnt_q < C_FULL) begin
        if (cnt_q == C_DATA0) begin
          shadow_d = rd_data;
          sdo_d    = rd_data[DATA_W-1];
          oe_d     = 1'b1;
        end else begin
          sdo_d = shadow_q[bit_idx[DB_W-1:0]];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      sh_q     <= '0;
      rd_q     <= 1'b0;
      shadow_q <= '0;
      sdo_q    <= 1'b0;
      oe_q     <= 1'b0;
      stb_q    <= 1'b0;
      waddr_q  <= '0;
      wdata_q  <= '0;
    end else begin
      cnt_q    <= cnt_d;
      sh_q     <= sh_d;
      rd_q     <= rd_d;
      shadow_q <= shadow_d;
      sdo_q    <= sdo_d;
      oe_q     <= oe_d;
      stb_q    <= stb_d;
      waddr_q  <= waddr_d;
      wdata_q  <= wdata_d;
    end
  end

  assign rd_addr = sh_q[ADDR_W-1:0];
  assign wr_stb  = stb_q;
  assign wr_addr = waddr_q;
  assign wr_data = wdata_q;
  assign sdo     = sdo_q;
  assign sdo_oe  = oe_q;

  a_r9_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= C_FULL);
  a_r7_commit_after_full: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (cnt_q == C_FULL));
  a_r1_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  a_r3_release_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_act |=> !sdo_oe);
endmodule

// File: rtl/serreg_regs.sv
module serreg_regs
  import serreg_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_stb,
  input  addr_t                    wr_addr,
  input  byte_t                    wr_data,
  input  addr_t                    rd_addr,
  input  logic [NUM_RO*DATA_W-1:0] sts_flat,
  output byte_t                    rd_data,
  output logic [NUM_RW*DATA_W-1:0] cfg_flat
);
  for (genvar i = 0; i < NUM_RW; i++) begin : g_rw
    byte_t q_r, d_r;
    logic  hit;
    assign hit = wr_stb && (wr_addr == RW_ADDR[i]);
    always_comb d_r = hit ? wr_data : q_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r <= RW_RST[i];
      else        q_r <= d_r;
    end
    assign cfg_flat[i*DATA_W +: DATA_W] = q_r;

    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && wr_addr == RW_ADDR[i]) |=> (cfg_flat[i*DATA_W +: DATA_W] == $past(wr_data)));
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_RW; i++)
      if (rd_addr == RW_ADDR[i]) rd_data = cfg_flat[i*DATA_W +: DATA_W];
    for (int j = 0; j < NUM_RO; j++)
      if (rd_addr == RO_ADDR[j]) rd_data = sts_flat[j*DATA_W +: DATA_W];
  end

  a_r8_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(cfg_flat));
endmodule

// File: rtl/serreg_if.sv
module serreg_if
  import serreg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_clk,
  input  logic       ser_en_n,
  input  logic       ser_din,
  output logic       ser_dout,
  output logic       ser_doe,
  input  logic [7:0] sts_reg7,
  input  logic [7:0] sts_reg8,
  input  logic [7:0] sts_reg13,
  input  logic [7:0] sts_reg14,
  input  logic [7:0] sts_reg16,
  output logic [7:0] cfg_reg1,
  output logic [7:0] cfg_reg2,
  output logic [7:0] cfg_reg3,
  output logic [7:0] cfg_reg4,
  output logic [7:0] cfg_reg5,
  output logic [7:0] cfg_reg6,
  output logic [7:0] cfg_reg9,
  output logic       soft_rst
);
  logic rise, fall, act, sdi;
  logic wr_stb;
  addr_t wr_addr, rd_addr;
  byte_t wr_data, rd_data;
  logic [NUM_RO*DATA_W-1:0] sts_flat;
  logic [NUM_RW*DATA_W-1:0] cfg_flat;

  serreg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk_i(ser_clk), .sen_ni(ser_en_n), .sdi_i(ser_din),
    .sclk_rise(rise), .sclk_fall(fall), .frame_act(act), .sdi_s(sdi)
  );

  serreg_frame u_frame (
    .clk(clk), .rst_n(rst_n), .sclk_rise(rise), .sclk_fall(fall), .frame_act(act),
    .sdi_s(sdi), .rd_data(rd_data), .rd_addr(rd_addr), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .sdo(ser_dout), .sdo_oe(ser_doe)
  );

  assign sts_flat = {sts_reg16, sts_reg14, sts_reg13, sts_reg8, sts_reg7};

  serreg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .sts_flat(sts_flat), .rd_data(rd_data), .cfg_flat(cfg_flat)
  );

  assign cfg_reg1 = cfg_flat[0*DATA_W +: DATA_W];
  assign cfg_reg2 = cfg_flat[1*DATA_W +: DATA_W];
  assign cfg_reg3 = cfg_flat[2*DATA_W +: DATA_W];
  assign cfg_reg4 = cfg_flat[3*DATA_W +: DATA_W];
  assign cfg_reg5 = cfg_flat[4*DATA_W +: DATA_W];
  assign cfg_reg6 = cfg_flat[5*DATA_W +: DATA_W];
  assign cfg_reg9 = cfg_flat[6*DATA_W +: DATA_W];
  assign soft_rst = cfg_flat[SRST_IDX*DATA_W + SRST_BIT];

  a_r6_srst_tracks_bit: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst == cfg_reg1[7]);
endmodule

// File: tb/tb_serreg_if.sv
module tb_serreg_if;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_en_n = 1'b1, ser_din = 1'b0;
  logic ser_dout, ser_doe, soft_rst;
  logic [7:0] sts_reg7 = 8'h00, sts_reg8 = 8'h00, sts_reg13 = 8'h00, sts_reg14 = 8'h00, sts_reg16 = 8'h00;
  logic [7:0] cfg_reg1, cfg_reg2, cfg_reg3, cfg_reg4, cfg_reg5, cfg_reg6, cfg_reg9;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct { logic [7:0] exp; string tag; } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  serreg_if dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_en_n(ser_en_n), .ser_din(ser_din),
    .ser_dout(ser_dout), .ser_doe(ser_doe), .sts_reg7(sts_reg7), .sts_reg8(sts_reg8),
    .sts_reg13(sts_reg13), .sts_reg14(sts_reg14), .sts_reg16(sts_reg16),
    .cfg_reg1(cfg_reg1), .cfg_reg2(cfg_reg2), .cfg_reg3(cfg_reg3), .cfg_reg4(cfg_reg4),
    .cfg_reg5(cfg_reg5), .cfg_reg6(cfg_reg6), .cfg_reg9(cfg_reg9), .soft_rst(soft_rst)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // 5 MHz serial clock: 100 ns per phase, data changed on falling edges.
  task automatic xfer(input bit rd, input logic [6:0] a, input logic [7:0] d,
                      input int nbits, input string tag);
    logic [15:0] w;
    w = {rd, a, d};
    if (rd && nbits >= 16) sb_q.push_back('{exp: d, tag: tag});
    ser_en_n = 1'b0;
    #100;
    for (int i = 0; i < nbits; i++) begin
      ser_din = (i < 16) ? (rd && i >= 8 ? 1'b0 : w[15-i]) : 1'b1;
      #100 ser_clk = 1'b1;
      #100 ser_clk = 1'b0;
    end
    #100 ser_en_n = 1'b1;
    ser_din = 1'b0;
    #400;
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    xfer(1'b0, a, d, 16, "");
  endtask

  task automatic rd(input logic [6:0] a, input logic [7:0] exp, input string tag);
    xfer(1'b1, a, exp, 16, tag);
  endtask

  // Monitor: decodes frames at the serial sampling edges and scores read data.
  int bp = 0;
  logic frd = 1'b0, oe_bad = 1'b0;
  logic [7:0] got = 8'h00;
  always @(negedge ser_en_n) begin bp = 0; oe_bad = 1'b0; got = 8'h00; end
  always @(posedge ser_clk) begin
    if (!ser_en_n) begin
      if (bp == 0) frd = ser_din;
      if (bp < 16) begin
        if (ser_doe !== (frd && bp >= 8)) oe_bad = 1'b1;
        if (frd && bp >= 8) got = {got[6:0], ser_dout};
        if (frd && bp == 15) begin
          checks++;
          if (sb_q.size() == 0) begin
            errors++;
            $display("FAIL R1: actual=%02h expected=<none queued>", got);
          end else begin
            exp_t e;
            e = sb_q.pop_front();
            if (got !== e.exp) begin
              errors++;
              $display("FAIL %s: actual=%02h expected=%02h", e.tag, got, e.exp);
            end
          end
        end
      end
      bp++;
    end
  end
  always @(posedge ser_en_n) begin
    if (bp > 0) begin
      checks++;
      if (oe_bad) begin
        errors++;
        $display("FAIL R3: actual=oe misplaced expected=oe only on read data edges");
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #50 rst_n = 1'b1;
    #100;
    // R4 reset state at the ports
    check("R4 reg1", cfg_reg1, 8'h00);
    check("R4 reg2", cfg_reg2, 8'h10);
    check("R4 reg3", cfg_reg3, 8'h90);
    check("R4 reg4", cfg_reg4, 8'h4F);
    check("R4 reg5", cfg_reg5, 8'h00);
    check("R4 reg6", cfg_reg6, 8'h22);
    check("R4 reg9", cfg_reg9, 8'h00);
    check("R4 doe", {7'd0, ser_doe}, 8'h00);
    check("R6 srst reset", {7'd0, soft_rst}, 8'h00);
    // R4 reset values through the serial read path (R1, R3)
    rd(7'd1, 8'h00, "R4 rd1");
    rd(7'd2, 8'h10, "R4 rd2");
    rd(7'd3, 8'h90, "R4 rd3");
    rd(7'd4, 8'h4F, "R4 rd4");
    rd(7'd6, 8'h22, "R4 rd6");
    // R5 status reads
    sts_reg7 = 8'hC3; sts_reg8 = 8'h5E; sts_reg13 = 8'h81; sts_reg14 = 8'h3A; sts_reg16 = 8'hF0;
    rd(7'd7,  8'hC3, "R5 rd7");
    rd(7'd8,  8'h5E, "R5 rd8");
    rd(7'd13, 8'h81, "R5 rd13");
    rd(7'd14, 8'h3A, "R5 rd14");
    rd(7'd16, 8'hF0, "R5 rd16");
    // R2 writes to the writable set
    wr(7'd2, 8'hA5);
    check("R2 reg2", cfg_reg2, 8'hA5);
    wr(7'd6, 8'h3C);
    check("R2 reg6", cfg_reg6, 8'h3C);
    wr(7'd9, 8'hFF);
    check("R2 reg9", cfg_reg9, 8'hFF);
    rd(7'd9, 8'hFF, "R1 rd9");
    // R1 alternating patterns on one register
    wr(7'd5, 8'h5A); rd(7'd5, 8'h5A, "R1 pat5A");
    wr(7'd5, 8'hA5); rd(7'd5, 8'hA5, "R1 patA5");
    wr(7'd5, 8'h01); rd(7'd5, 8'h01, "R1 pat01");
    // R5 writes to read-only addresses ignored
    wr(7'd7, 8'h11);
    rd(7'd7, 8'hC3, "R5 ro7 unchanged");
    wr(7'd16, 8'h00);
    rd(7'd16, 8'hF0, "R5 ro16 unchanged");
    // R8 unimplemented addresses
    wr(7'h20, 8'h77);
    check("R8 reg1", cfg_reg1, 8'h00);
    check("R8 reg2", cfg_reg2, 8'hA5);
    check("R8 reg3", cfg_reg3, 8'h90);
    check("R8 reg4", cfg_reg4, 8'h4F);
    check("R8 reg5", cfg_reg5, 8'h01);
    check("R8 reg6", cfg_reg6, 8'h3C);
    check("R8 reg9", cfg_reg9, 8'hFF);
    rd(7'h20, 8'h00, "R8 rd20");
    rd(7'h7F, 8'h00, "R8 rd7F");
    rd(7'h00, 8'h00, "R8 rd00");
    // R7 aborted frames
    xfer(1'b0, 7'd3, 8'h55, 12, "");
    check("R7 abort12", cfg_reg3, 8'h90);
    xfer(1'b0, 7'd3, 8'h55, 15, "");
    check("R7 abort15", cfg_reg3, 8'h90);
    rd(7'd3, 8'h90, "R7 rd3 after abort");
    // R9 extra clocks after the 16th
    xfer(1'b0, 7'd4, 8'h12, 20, "");
    check("R9 reg4", cfg_reg4, 8'h12);
    rd(7'd4, 8'h12, "R9 rd4");
    // R6 soft reset request
    wr(7'd1, 8'h80);
    check("R6 srst set", {7'd0, soft_rst}, 8'h01);
    check("R6 reg2 kept", cfg_reg2, 8'hA5);
    rd(7'd2, 8'hA5, "R6 port alive");
    wr(7'd1, 8'h00);
    check("R6 srst clear", {7'd0, soft_rst}, 8'h00);
    // R10 full-rate read at 5 MHz
    rd(7'd6, 8'h3C, "R10 rd6");
    #200;
    checks++;
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL R3: actual=%0d unread expected=0", sb_q.size());
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule